// File: doc/BRIEF.md
# Posted-Store Buffer with Drain Barrier

This block sits between a core's store port and the coherence interface of its cache. The core hands over a store, and the store is accepted in the same cycle as long as a slot is free. The core does not wait for other caches. Each held store keeps its address and data and has a per-slot ready flag. The flag is set when the coherence fabric returns the invalidate acknowledgement for that store. The acknowledgement names the store by the slot tag that the block reported when it accepted the store. Acknowledgements may come back in any order.

Stores leave the buffer toward the cache strictly oldest first. The oldest store leaves only once its own acknowledgement has been seen. A younger store that is already acknowledged waits behind it. While stores are held, a load lookup returns the data of the youngest held store to the same address. A store-barrier request holds the core stalled until every held store has been committed. The same stall output also reports a store that cannot be accepted because the buffer is full.

Top module: `store_drain_buf`

## Requirements
- R1: After reset the buffer is empty: cm_valid is 0, st_ready is 1, ld_hit is 0 and core_stall is 0.
- R2: A store is accepted in a cycle where st_valid and st_ready are both 1. In that cycle st_tag shows the slot that the store takes. Slots are handed out in ring order 0, 1, ..., DEPTH-1, 0, starting at slot 0 after reset.
- R3: A held store is never presented on the commit output before an acknowledgement carrying its tag has been sampled. The acknowledgement is sampled at a clock edge. The store can appear on cm_valid/cm_addr/cm_data from the next cycle on. It leaves the buffer at the edge that ends the cycle in which it is presented.
- R4: Commits follow acceptance order. While the oldest store is unacknowledged, cm_valid stays 0, even if younger stores are acknowledged.
- R5: An acknowledgement is applied only to its own slot, in any order. An acknowledgement whose tag names an empty slot has no effect. A store later placed in that slot still needs its own acknowledgement.
- R6: With DEPTH stores held and no commit in the current cycle, st_ready is 0. A store offered in that state is not accepted, and core_stall is 1.
- R7: With DEPTH stores held and a commit in the current cycle, st_ready is 1. A store offered in that cycle is accepted into the slot being freed.
- R8: ld_hit is 1 when ld_addr equals the address of any held store. ld_data is then the data of the youngest such store. With no match, ld_hit is 0.
- R9: While barrier_req is 1 and the buffer holds at least one store, core_stall is 1. With barrier_req at 1 and the buffer empty, core_stall follows only the full condition of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_valid | input | 1 | Core offers a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_tag | output | TW | Slot the offered store takes |
| ack_valid | input | 1 | Invalidate acknowledgement arrives |
| ack_tag | input | TW | Slot the acknowledgement belongs to |
| ld_addr | input | AW | Load lookup address |
| ld_hit | output | 1 | A held store matches ld_addr |
| ld_data | output | DW | Data of the youngest matching store |
| cm_valid | output | 1 | Oldest store is committed to the cache this cycle |
| cm_addr | output | AW | Address of the committing store |
| cm_data | output | DW | Data of the committing store |
| barrier_req | input | 1 | Store barrier in progress |
| core_stall | output | 1 | Core must hold (full or barrier draining) |

## Verification
Random traffic draws addresses from a set of four values, so that lookups often match several held stores and the youngest-match rule is separated from an oldest-match or first-slot rule. Acknowledgements are sent with tags picked at random among the held stores, plus some tags for empty slots. This separates strict in-order commit from commit-on-ack, and it exposes an acknowledgement that lands on the wrong or an empty slot. Directed sequences fill the buffer without acknowledgements, acknowledge younger entries first, offer a store into a full buffer in a cycle with and without a commit, and hold a barrier through a complete drain. These cases separate a correct full test from one that stalls falsely, and a barrier that waits for the buffer to be empty from one that releases early.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    // Position of the entry that is k places younger than slot p in a ring of n slots.
    function automatic int unsigned ring_at(int unsigned p, int unsigned k, int unsigned n);
        return (p + k) % n;
    endfunction

endpackage

// File: rtl/sdb_fwd.sv
module sdb_fwd #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]         slot_vld,
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    input  logic [DEPTH-1:0][DW-1:0] slot_data,
    input  logic [PW-1:0]            head,
    input  logic [AW-1:0]            look_addr,
    output logic                     look_hit,
    output logic [DW-1:0]            look_data
);
    import sdb_pkg::*;

    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int unsigned idx;
            idx = ring_at(int'(head), k, DEPTH);
            if (slot_vld[idx] && (slot_addr[idx] == look_addr)) begin
                look_hit  = 1'b1;
                look_data = slot_data[idx];
            end
        end
    end

endmodule

// File: rtl/sdb_stall.sv
module sdb_stall (
    input  logic offer,
    input  logic accept_ok,
    input  logic barrier,
    input  logic empty,
    output logic stall
);
    logic full_block;
    logic drain_block;

    always_comb begin
        full_block  = offer && !accept_ok;
        drain_block = barrier && !empty;
        stall       = full_block || drain_block;
    end

endmodule

// File: rtl/store_drain_buf.sv
module store_drain_buf #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_ready,
    output logic [TW-1:0] st_tag,
    input  logic          ack_valid,
    input  logic [TW-1:0] ack_tag,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    output logic          cm_valid,
    output logic [AW-1:0] cm_addr,
    output logic [DW-1:0] cm_data,
    input  logic          barrier_req,
    output logic          core_stall
);

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0]         rdy;
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [TW-1:0]            head;
        logic [TW-1:0]            tail;
        logic [CW-1:0]            cnt;
    } sb_state_t;

    sb_state_t state_d, state_q;

    logic          commit_now;
    logic          push_now;
    logic          is_full;
    logic          is_empty;
    logic [CW-1:0] occ;

    function automatic logic [TW-1:0] ptr_next(logic [TW-1:0] p);
        return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign occ      = state_q.cnt;
    assign is_full  = (state_q.cnt == CW'(DEPTH));
    assign is_empty = (state_q.cnt == '0);

    always_comb begin
        state_d    = state_q;
        commit_now = state_q.vld[state_q.head] && state_q.rdy[state_q.head];
        st_ready   = !is_full || commit_now;
        push_now   = st_valid && st_ready;
        st_tag     = state_q.tail;
        cm_valid   = commit_now;
        cm_addr    = state_q.addr[state_q.head];
        cm_data    = state_q.data[state_q.head];

        // retire the oldest entry
        if (commit_now) begin
            state_d.vld[state_q.head] = 1'b0;
            state_d.rdy[state_q.head] = 1'b0;
            state_d.head              = ptr_next(state_q.head);
        end

        // acknowledgement marks a still-held slot ready
        if (ack_valid && (int'(ack_tag) < DEPTH)) begin
            if (state_d.vld[ack_tag]) begin
                state_d.rdy[ack_tag] = 1'b1;
            end
        end

        // new store takes the tail slot and waits for its own ack
        if (push_now) begin
            state_d.vld[state_q.tail]  = 1'b1;
            state_d.rdy[state_q.tail]  = 1'b0;
            state_d.addr[state_q.tail] = st_addr;
            state_d.data[state_q.tail] = st_data;
            state_d.tail               = ptr_next(state_q.tail);
        end

        state_d.cnt = state_q.cnt + CW'(push_now) - CW'(commit_now);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    sdb_fwd #(
        .DEPTH(DEPTH),
        .AW   (AW),
        .DW   (DW)
    ) u_fwd (
        .slot_vld (state_q.vld),
        .slot_addr(state_q.addr),
        .slot_data(state_q.data),
        .head     (state_q.head),
        .look_addr(ld_addr),
        .look_hit (ld_hit),
        .look_data(ld_data)
    );

    sdb_stall u_stall (
        .offer    (st_valid),
        .accept_ok(st_ready),
        .barrier  (barrier_req),
        .empty    (is_empty),
        .stall    (core_stall)
    );

endmodule

// File: rtl/sdb_checker.sv
module sdb_checker #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          cm_valid,
    input logic          ld_hit,
    input logic          barrier_req,
    input logic          core_stall,
    input logic [CW-1:0] occ
);

    // R6: occupancy never exceeds the capacity
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    // R6: a full buffer without a commit refuses the store and stalls the core
    p_full_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occ) == DEPTH && !cm_valid && st_valid) |-> (!st_ready && core_stall));

    // R3: nothing commits from an empty buffer
    p_empty_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !cm_valid);

    // R2: accepting without a commit grows the occupancy by one
    p_accept_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && !cm_valid) |=> (int'(occ) == int'($past(occ)) + 1));

    // R7: accept and commit together keep the occupancy
    p_swap_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && cm_valid) |=> (occ == $past(occ)));

    // R8: no forwarding hit from an empty buffer
    p_empty_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !ld_hit);

    // R9: barrier with held stores stalls the core
    p_barrier_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (barrier_req && occ != '0) |-> core_stall);

endmodule

bind store_drain_buf sdb_checker #(
    .DEPTH(DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .cm_valid   (cm_valid),
    .ld_hit     (ld_hit),
    .barrier_req(barrier_req),
    .core_stall (core_stall),
    .occ        (occ)
);

// File: tb/store_drain_buf_tb.sv
module store_drain_buf_tb;

    localparam int  DEPTH     = 4;
    localparam int  AW        = 32;
    localparam int  DW        = 32;
    localparam int  TW        = 2;
    localparam time CLK_P     = 10ns;
    localparam int  MAX_CYC   = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_ready;
    logic [TW-1:0] st_tag;
    logic          ack_valid = 1'b0;
    logic [TW-1:0] ack_tag = '0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_hit;
    logic [DW-1:0] ld_data;
    logic          cm_valid;
    logic [AW-1:0] cm_addr;
    logic [DW-1:0] cm_data;
    logic          barrier_req = 1'b0;
    logic          core_stall;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    // reference model
    logic [AW-1:0] m_addr[$];
    logic [DW-1:0] m_data[$];
    logic [TW-1:0] m_tag[$];
    bit            m_ack[$];
    logic [TW-1:0] m_next = '0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc++;

    store_drain_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_ready(st_ready), .st_tag(st_tag),
        .ack_valid(ack_valid), .ack_tag(ack_tag),
        .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data),
        .barrier_req(barrier_req), .core_stall(core_stall)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    function automatic bit exp_commit();
        return (m_addr.size() > 0) && m_ack[0];
    endfunction

    function automatic bit exp_ready();
        return (m_addr.size() < DEPTH) || exp_commit();
    endfunction

    // one cycle: drive at negedge, check outputs, advance model at posedge
    task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                        input bit av, input logic [TW-1:0] at,
                        input logic [AW-1:0] la, input bit bar);
        bit e_cm, e_rdy, e_hit, e_stall, push;
        logic [DW-1:0] e_ld;
        st_valid = sv; st_addr = sa; st_data = sd;
        ack_valid = av; ack_tag = at; ld_addr = la; barrier_req = bar;
        #1;
        e_cm  = exp_commit();
        e_rdy = exp_ready();
        e_hit = 1'b0; e_ld = '0;
        foreach (m_addr[i]) if (m_addr[i] == la) begin e_hit = 1'b1; e_ld = m_data[i]; end
        e_stall = (sv && !e_rdy) || (bar && m_addr.size() > 0);
        chk(cm_valid == e_cm, "R3/R4 cm_valid", cm_valid, e_cm);
        if (e_cm) begin
            chk(cm_addr == m_addr[0], "R4 cm_addr", cm_addr, m_addr[0]);
            chk(cm_data == m_data[0], "R4 cm_data", cm_data, m_data[0]);
        end
        chk(st_ready == e_rdy,
            (m_addr.size() == DEPTH) ? (e_cm ? "R7 st_ready" : "R6 st_ready") : "R2 st_ready",
            st_ready, e_rdy);
        if (sv && e_rdy) chk(st_tag == m_next, "R2 st_tag", st_tag, m_next);
        chk(ld_hit == e_hit, "R8 ld_hit", ld_hit, e_hit);
        if (e_hit) chk(ld_data == e_ld, "R8 ld_data", ld_data, e_ld);
        chk(core_stall == e_stall, bar ? "R9 core_stall" : "R6 core_stall", core_stall, e_stall);
        push = sv && e_rdy;
        @(posedge clk);
        if (e_cm) begin
            void'(m_addr.pop_front()); void'(m_data.pop_front());
            void'(m_tag.pop_front());  void'(m_ack.pop_front());
        end
        if (av) foreach (m_tag[i]) if (m_tag[i] == at) m_ack[i] = 1'b1;
        if (push) begin
            m_addr.push_back(sa); m_data.push_back(sd);
            m_tag.push_back(m_next); m_ack.push_back(1'b0);
            m_next = (m_next == TW'(DEPTH-1)) ? '0 : m_next + 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b0);
    endtask

    initial begin : watchdog
        #(CLK_P * MAX_CYC);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired at cycle %0d: actual=hung expected=finished", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cm_valid == 1'b0, "R1 cm_valid", cm_valid, 0);
        chk(st_ready == 1'b1, "R1 st_ready", st_ready, 1);
        chk(ld_hit == 1'b0, "R1 ld_hit", ld_hit, 0);
        chk(core_stall == 1'b0, "R1 core_stall", core_stall, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R6: fill without acks, then offer into a full buffer
        for (int i = 0; i < DEPTH; i++) step(1'b1, 32'h100 + i, 32'hA0 + i, 1'b0, '0, 32'h100, 1'b0);
        st_valid = 1'b1; st_addr = 32'h200; #1;
        chk(st_ready == 1'b0, "R6 full refuses", st_ready, 0);
        chk(core_stall == 1'b1, "R6 full stalls", core_stall, 1);
        step(1'b1, 32'h200, 32'hBB, 1'b0, '0, 32'h103, 1'b0);
        // R4/R5: acknowledge younger entries first; head must still hold
        step(1'b0, '0, '0, 1'b1, 2'd2, '0, 1'b0);
        step(1'b0, '0, '0, 1'b1, 2'd1, '0, 1'b0);
        #1 chk(cm_valid == 1'b0, "R4 head blocks younger", cm_valid, 0);
        // R3: ack head; commit appears next cycle; R7: push into the slot being freed
        step(1'b0, '0, '0, 1'b1, 2'd0, '0, 1'b0);
        st_valid = 1'b1; #1;
        chk(cm_valid && cm_addr == 32'h100, "R3 head commit after ack", cm_addr, 32'h100);
        chk(st_ready == 1'b1, "R7 full with commit accepts", st_ready, 1);
        step(1'b1, 32'h101, 32'hC5, 1'b0, '0, 32'h101, 1'b0);
        // R8: youngest of two stores to 0x101 forwards
        ld_addr = 32'h101; st_valid = 1'b0; #1;
        chk(ld_hit && ld_data == 32'hC5, "R8 youngest match", ld_data, 32'hC5);
        // R9: barrier held through the full drain
        step(1'b0, '0, '0, 1'b1, 2'd3, '0, 1'b1);
        step(1'b0, '0, '0, 1'b1, 2'd0, '0, 1'b1);
        for (int i = 0; i < 8; i++) step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1);
        barrier_req = 1'b1; st_valid = 1'b0; #1;
        chk(core_stall == 1'b0, "R9 barrier released when empty", core_stall, 0);
        // R5: ack to an empty slot, then a store placed there still waits
        step(1'b0, '0, '0, 1'b1, m_next, '0, 1'b0);
        step(1'b1, 32'h300, 32'h33, 1'b0, '0, '0, 1'b0);
        idle();
        #1 chk(cm_valid == 1'b0, "R5 stray ack ignored", cm_valid, 0);
        step(1'b0, '0, '0, 1'b1, m_tag[0], '0, 1'b0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            bit sv, av, bar;
            logic [TW-1:0] at;
            sv  = ($urandom_range(0, 99) < 55);
            av  = ($urandom_range(0, 99) < 45);
            bar = ($urandom_range(0, 99) < 6);
            if (m_tag.size() > 0 && $urandom_range(0, 9) < 8)
                at = m_tag[$urandom_range(0, m_tag.size() - 1)];
            else
                at = TW'($urandom_range(0, DEPTH - 1));
            step(sv, 32'h40 + 32'($urandom_range(0, 3)), $urandom(), av, at,
                 32'h40 + 32'($urandom_range(0, 4)), bar);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule